// File: doc/BRIEF.md
# Matrix element index remapper

This block converts the plain element sequence of a vector loop into a reshaped sequence of element indices. A 32-bit shape word describes the vector as a one-, two- or three-dimensional array. Three nested counters walk that array in a chosen loop order. Each dimension can run forwards or backwards, and any one loop level can be left out of the output index. A small constant is added to every result. Dimension sizes are arbitrary and need not be powers of two.

A controller loads a shape word and a vector length with a start pulse. The block then presents one index at a time. The consumer takes each index with a step pulse, and the block flags the final element of the run. Runs longer than the array simply restart the array walk until the vector length is used up.

Top module: `mtx_idx_remap`

## Requirements
- R1: The shape word is decoded as follows. Bits 5:0, 11:6 and 17:12 hold the x, y and z sizes minus one, so a value of 0 means one element. Bits 20:18 hold the loop order, bits 23:21 the per-dimension reversal flags (bit 21 is x, bit 22 is y, bit 23 is z), bits 27:24 the offset, bits 29:28 the skip selector and bits 31:30 the mode. The array walk is used only when the mode is 00 and the loop order is 0 to 5.
- R2: A start pulse loads the shape word and the vector length. If the length is nonzero, ready_o is high in the next cycle and the first index is presented. If the length is zero, ready_o stays low.
- R3: While ready_o is high, each cycle with step_i high moves to the next element. Without step_i, idx_o and ready_o hold their values.
- R4: The loop order, fastest loop first, is: 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x.
- R5: When a dimension's reversal flag is set, that dimension contributes size-1 down to 0 instead of 0 up to size-1.
- R6: Skip value 1, 2 or 3 drops the fastest, middle or slowest loop level from the index. Skip value 0 keeps all levels.
- R7: The index is the sum of the contributions of the levels that are kept. Each contribution is weighted by the product of the sizes of the kept levels that lie inside it.
- R8: The 4-bit offset field is added to every array-walk index.
- R9: An all-zero shape word, or any word that does not select the array walk, makes idx_o equal to the element number 0, 1, 2, and so on.
- R10: When the vector length exceeds the array size, the walk wraps to its start position and continues until the full vector length has been emitted.
- R11: done_o is high only while the last element of the run is presented. After that element is stepped, ready_o falls, and idx_o reads 0 while ready_o is low.
- R12: A start pulse during a run abandons that run. The new run begins from element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Loads the shape and the length and begins a run |
| shape_i | input | 32 | Shape word |
| vl_i | input | VL_W | Vector length, 0 to 127 |
| step_i | input | 1 | Consumes the presented index |
| ready_o | output | 1 | An index is presented |
| idx_o | output | IDX_W | Remapped element index |
| done_o | output | 1 | The presented index is the last of the run |

## Verification
The hardest case to reach is a carry that ripples through all three loop levels while a reversal flag and a skip are active at the same time. This only happens on the one step where the two inner counters both sit at their final values. The bench reaches it with small three-dimensional shapes such as 2x3x2 in several loop orders, with vector lengths longer than the array so that the full wrap back to the start is also crossed. Restart in the middle of a run and holds without a step are driven between steps, with the port values checked at those points.

// File: rtl/mir_pkg.sv
package mir_pkg;
  localparam int DIM_W = 6;
  localparam int IDX_W = 3 * DIM_W + 1;

  typedef logic [1:0] dim_id_t;

  typedef struct packed {
    logic [1:0]       mode;
    logic [1:0]       skip;
    logic [3:0]       offset;
    logic [2:0]       inv;
    logic [2:0]       perm;
    logic [DIM_W-1:0] zsz;
    logic [DIM_W-1:0] ysz;
    logic [DIM_W-1:0] xsz;
  } shape_t;

  // dimension walked at loop level pos (0 = fastest)
  function automatic dim_id_t loop_dim(input logic [2:0] perm, input int unsigned pos);
    dim_id_t r;
    case (perm)
      3'd1:    r = (pos == 0) ? 2'd0 : (pos == 1) ? 2'd2 : 2'd1;
      3'd2:    r = (pos == 0) ? 2'd1 : (pos == 1) ? 2'd0 : 2'd2;
      3'd3:    r = (pos == 0) ? 2'd1 : (pos == 1) ? 2'd2 : 2'd0;
      3'd4:    r = (pos == 0) ? 2'd2 : (pos == 1) ? 2'd0 : 2'd1;
      3'd5:    r = (pos == 0) ? 2'd2 : (pos == 1) ? 2'd1 : 2'd0;
      default: r = (pos == 0) ? 2'd0 : (pos == 1) ? 2'd1 : 2'd2;
    endcase
    return r;
  endfunction

  function automatic logic walk_enabled(input shape_t s);
    return (s != '0) && (s.mode == 2'b00) && (s.perm < 3'd6);
  endfunction
endpackage

// File: rtl/mir_dim_ctr.sv
module mir_dim_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         at_last_o
);
  assign at_last_o = (cnt_o == last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= '0;
    else if (inc_i)  cnt_o <= at_last_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/mir_idx_calc.sv
module mir_idx_calc
  import mir_pkg::*;
#(
  parameter int DW = DIM_W,
  parameter int IW = IDX_W
) (
  input  shape_t              shape_i,
  input  logic [2:0][DW-1:0]  cnt_i,
  output logic [IW-1:0]       idx_o
);
  function automatic logic [IW-1:0] fold(input shape_t s, input logic [2:0][DW-1:0] c);
    logic [IW-1:0] acc, stride;
    logic [DW-1:0] sz_m1, e;
    dim_id_t d;
    acc = '0;
    stride = IW'(1);
    for (int p = 0; p < 3; p++) begin
      d = loop_dim(s.perm, p);
      sz_m1 = (d == 2'd0) ? s.xsz : (d == 2'd1) ? s.ysz : s.zsz;
      e = s.inv[d] ? (sz_m1 - c[d]) : c[d];
      if (s.skip != 2'(p + 1)) begin
        acc = acc + IW'(e) * stride;
        stride = stride * (IW'(sz_m1) + IW'(1));
      end
    end
    return acc + IW'(s.offset);
  endfunction

  assign idx_o = fold(shape_i, cnt_i);
endmodule

// File: rtl/mtx_idx_remap.sv
module mtx_idx_remap
  import mir_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       shape_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              step_i,
  output logic              ready_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o
);
  shape_t            shape_q;
  logic [VL_W-1:0]   vl_q, elem_q;
  logic              run_q;
  logic              adv_w, last_w;
  logic [2:0][DIM_W-1:0] cnt_w, size_m1;
  logic [2:0]        at_last, inc_dim;
  dim_id_t           dim_at [3];
  logic [IDX_W-1:0]  walk_idx;

  assign adv_w  = run_q && step_i;
  assign last_w = run_q && (elem_q == vl_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= '0;
      vl_q    <= '0;
      elem_q  <= '0;
      run_q   <= 1'b0;
    end else if (start_i) begin
      shape_q <= shape_t'(shape_i);
      vl_q    <= vl_i;
      elem_q  <= '0;
      run_q   <= (vl_i != '0);
    end else if (adv_w) begin
      elem_q <= elem_q + 1'b1;
      if (last_w) run_q <= 1'b0;
    end
  end

  assign size_m1 = {shape_q.zsz, shape_q.ysz, shape_q.xsz};

  always_comb begin
    for (int p = 0; p < 3; p++) dim_at[p] = loop_dim(shape_q.perm, p);
  end

  // a level advances when every faster level sits at its final value
  always_comb begin
    for (int d = 0; d < 3; d++) begin
      logic found;
      found = 1'b0;
      inc_dim[d] = adv_w;
      for (int p = 0; p < 3; p++) begin
        if (!found) begin
          if (dim_at[p] == 2'(d)) found = 1'b1;
          else inc_dim[d] = inc_dim[d] & at_last[dim_at[p]];
        end
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_dim
    mir_dim_ctr #(.W(DIM_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_i),
      .inc_i     (inc_dim[g]),
      .last_i    (size_m1[g]),
      .cnt_o     (cnt_w[g]),
      .at_last_o (at_last[g])
    );
  end

  mir_idx_calc u_calc (
    .shape_i (shape_q),
    .cnt_i   (cnt_w),
    .idx_o   (walk_idx)
  );

  assign ready_o = run_q;
  assign done_o  = last_w;
  assign idx_o   = !run_q ? '0 :
                   walk_enabled(shape_q) ? walk_idx : IDX_W'(elem_q);
endmodule

// File: rtl/mir_chk.sv
module mir_chk #(
  parameter int VL_W = 7,
  parameter int IW   = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [VL_W-1:0] vl_i,
  input logic            step_i,
  input logic            ready_o,
  input logic            done_o,
  input logic [IW-1:0]   idx_o,
  input logic [VL_W-1:0] elem,
  input logic [VL_W-1:0] vl
);
  AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o); // R11
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && step_i && done_o && !start_i |=> !ready_o); // R11
  AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && !step_i && !start_i |=> ready_o && $stable(idx_o)); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && step_i && !done_o && !start_i |=> elem == $past(elem) + 1'b1); // R3
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && vl_i != '0 |=> ready_o && elem == '0); // R2
  AST_EMPTY_VL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && vl_i == '0 |=> !ready_o); // R2
  AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> elem < vl); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> idx_o == '0); // R11
endmodule

bind mtx_idx_remap mir_chk #(.VL_W(VL_W), .IW(mir_pkg::IDX_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .vl_i    (vl_i),
  .step_i  (step_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .idx_o   (idx_o),
  .elem    (elem_q),
  .vl      (vl_q)
);

// File: tb/mtx_idx_remap_tb_top.sv
`timescale 1ns/1ps
module mtx_idx_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] shape_i = '0;
  logic [6:0]  vl_i = '0;
  logic        step_i = 1'b0;
  logic        ready_o, done_o;
  logic [18:0] idx_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mtx_idx_remap dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shape_i(shape_i),
    .vl_i(vl_i), .step_i(step_i), .ready_o(ready_o), .idx_o(idx_o), .done_o(done_o)
  );

  function automatic logic [31:0] mk(int x, int y, int z, int perm, int inv, int off, int skip);
    return {2'b00, 2'(skip), 4'(off), 3'(inv), 3'(perm), 6'(z - 1), 6'(y - 1), 6'(x - 1)};
  endfunction

  // reference: decompose the element number with div/mod, rebuild outermost-first
  function automatic int mdl(logic [31:0] s, int n);
    int sz[3];
    int ord[3];
    int p[3];
    int m, acc, d, v;
    sz[0] = int'(s[5:0]) + 1;
    sz[1] = int'(s[11:6]) + 1;
    sz[2] = int'(s[17:12]) + 1;
    if (s == 0 || s[31:30] != 0 || s[20:18] > 5) return n;
    case (s[20:18])
      3'd0: ord = '{0, 1, 2};
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    m = n % (sz[0] * sz[1] * sz[2]);
    p[0] = m % sz[ord[0]];
    p[1] = (m / sz[ord[0]]) % sz[ord[1]];
    p[2] = m / (sz[ord[0]] * sz[ord[1]]);
    acc = 0;
    for (int k = 2; k >= 0; k--) begin
      d = ord[k];
      v = s[21 + d] ? sz[d] - 1 - p[k] : p[k];
      if (int'(s[29:28]) != k + 1) acc = acc * sz[d] + v;
    end
    return acc + int'(s[27:24]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(logic [31:0] s, int vl);
    @(negedge clk);
    start_i = 1'b1; shape_i = s; vl_i = 7'(vl);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // checks elements first..first+cnt-1, stepping through each
  task automatic walk(string req, logic [31:0] s, int vl, int first, int cnt);
    for (int n = first; n < first + cnt; n++) begin
      chk(req, "ready", int'(ready_o), 1);
      chk(req, "idx", int'(idx_o), mdl(s, n));
      chk("R11", "done", int'(done_o), int'(n == vl - 1));
      step_i = 1'b1;
      @(negedge clk);
    end
    step_i = 1'b0;
    if (first + cnt == vl) begin
      chk("R11", "ready after last", int'(ready_o), 0);
      chk("R11", "idle idx", int'(idx_o), 0);
    end
  endtask

  task automatic run(string req, logic [31:0] s, int vl);
    do_start(s, vl);
    walk(req, s, vl, 0, vl);
  endtask

  task automatic t_reset();
    chk("R11", "reset ready", int'(ready_o), 0);
    chk("R11", "reset done", int'(done_o), 0);
    chk("R11", "reset idx", int'(idx_o), 0);
  endtask

  task automatic t_linear();
    run("R9", 32'h0, 9);
    run("R9", 32'h4000_0123, 6);            // mode 01
    run("R9", mk(3, 2, 1, 6, 0, 0, 0), 5);  // order code 6
  endtask

  task automatic t_orders();
    run("R4", mk(3, 4, 1, 0, 0, 0, 0), 12);
    run("R4", mk(3, 4, 1, 2, 0, 0, 0), 12);
    for (int pm = 0; pm < 6; pm++) run("R4", mk(2, 3, 2, pm, 0, 0, 0), 12);
  endtask

  task automatic t_invert();
    run("R5", mk(3, 4, 1, 0, 1, 0, 0), 12);
    run("R5", mk(2, 3, 2, 3, 7, 0, 0), 12);
    run("R5", mk(4, 1, 3, 4, 4, 0, 0), 12);
  endtask

  task automatic t_skip();
    run("R6", mk(3, 3, 1, 0, 0, 0, 1), 9);
    run("R6", mk(3, 3, 1, 0, 0, 0, 2), 9);
    run("R6", mk(2, 3, 2, 5, 2, 0, 3), 12);
    run("R7", mk(2, 3, 2, 1, 0, 0, 2), 12);
  endtask

  task automatic t_offset();
    run("R8", mk(3, 2, 1, 2, 0, 5, 0), 6);
    run("R8", mk(2, 2, 2, 0, 1, 15, 1), 8);
  endtask

  task automatic t_wrap();
    run("R10", mk(2, 3, 1, 0, 0, 0, 0), 15);
    run("R10", mk(2, 3, 2, 4, 5, 1, 0), 127);
    run("R1", mk(18, 1, 1, 0, 0, 0, 0), 40);
    run("R1", mk(1, 1, 50, 0, 0, 0, 0), 60);
  endtask

  task automatic t_empty_hold();
    logic [31:0] s;
    do_start(mk(3, 4, 1, 0, 0, 0, 0), 0);
    chk("R2", "ready with zero length", int'(ready_o), 0);
    s = mk(3, 4, 1, 2, 0, 0, 0);
    do_start(s, 12);
    walk("R3", s, 12, 0, 2);
    repeat (3) @(negedge clk);
    chk("R3", "held ready", int'(ready_o), 1);
    chk("R3", "held idx", int'(idx_o), mdl(s, 2));
    walk("R3", s, 12, 2, 10);
  endtask

  task automatic t_restart();
    logic [31:0] a, b;
    a = mk(3, 4, 1, 2, 0, 0, 0);
    b = mk(2, 2, 2, 5, 2, 3, 0);
    do_start(a, 12);
    walk("R12", a, 12, 0, 5);
    do_start(b, 8);
    walk("R12", b, 8, 0, 8);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_linear();
    t_orders();
    t_invert();
    t_skip();
    t_offset();
    t_wrap();
    t_empty_hold();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule